// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external 8-bit microprocessor exchange bytes with an on-chip CPU through two one-byte mailboxes. The external side uses three active-low strobes: chip select, read and write. These strobes are asynchronous to the system clock. The internal CPU reaches the same mailboxes through a small register interface clocked by `clk`. At the data address, a CPU write fills the outbound latch and a CPU read returns the inbound latch.

Status flags track whether each latch holds an unconsumed byte. An overflow flag records an external write that arrived while the inbound byte was still unread. A latched interrupt flag records every completed external access.

The port works only while its mode bit is set. The external strobes pass through synchronizers. An access counts when its strobe deasserts (rising edge) while chip select is low. The block drives `ext_dout` together with an output-enable, and the tristate pad sits outside the block.

Top module: `pport_slave`

## Requirements
- R1: After reset, the control register (address 1) reads 0x07, the interrupt register (address 2) reads 0x00, and `irq`, `ext_doe` and `ext_dout` are 0. Control layout: bit7 inbound full, bit6 outbound full, bit5 overflow, bit4 mode enable, bit3 reads 0, bits2:0 strobe direction bits (reset 1). Interrupt layout: bit0 access flag, bit1 interrupt enable.
- R2: A CPU write at address 0 loads the outbound latch. With mode on, it also sets outbound full. A completed external read clears outbound full. If both happen in one cycle, the CPU write wins.
- R3: With mode on, a completed external write loads `ext_din` into the inbound latch and sets inbound full. A CPU read at address 0 (`cpu_rd` high) returns the inbound latch and clears inbound full. Reading other addresses has no side effect.
- R4: With mode on, an external write that completes while inbound full is set sets overflow, keeps the held byte and discards the new one.
- R5: While mode is off, external strobes change no latch and no flag, and inbound full and outbound full read 0. A CPU write at address 0 while mode is off does not set outbound full after mode is turned back on.
- R6: Bits 7 and 6 of the control register cannot be written. A control write with bit5 = 0 clears overflow, and bit5 = 1 leaves it unchanged. Overflow stays set when mode is turned off.
- R7: With mode on, each completed external access sets the access flag. A write to address 2 with bit0 = 0 clears it, and bit0 = 1 leaves it unchanged. `irq` is high only when both the flag and the enable bit are set.
- R8: An access completes on the rising edge of the read or write strobe while chip select is low. The resulting flag change is visible on `cpu_rdata` in the third clock cycle after the edge. A strobe pulse with chip select high is ignored.
- R9: When an external write completes in the same cycle as a CPU read at address 0, the write wins. Inbound full stays set, the latch holds the new byte, and overflow is not set.
- R10: `ext_doe` is high only while mode is on, chip select is low and the read strobe is low. During that time `ext_dout` carries the outbound latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 2 | CPU register select: 0 data, 1 control, 2 interrupt |
| cpu_rd | input | 1 | CPU read strobe (side effect at address 0) |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data for the selected address |
| ext_cs_n | input | 1 | External chip select, active low, asynchronous |
| ext_rd_n | input | 1 | External read strobe, active low, asynchronous |
| ext_wr_n | input | 1 | External write strobe, active low, asynchronous |
| ext_din | input | DW | External write data |
| ext_dout | output | DW | Outbound latch toward the external bus |
| ext_doe | output | 1 | Drive enable for the external data bus |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted full or overflow flag shows up on the control register readback. It appears within three clock cycles of the strobe edge that should have moved it. A wrong inbound latch shows up as the wrong byte on the next CPU data read. A stuck outbound flag or latch shows up on `ext_dout` during the next external read. The same-cycle collision and the mode-off cases are checked at exact cycles, so an error in priority or masking changes a readback value rather than a timing.

// File: rtl/pport_pkg.sv
// Shared constants for the parallel slave port: CPU register selects,
// control and interrupt register bit positions, and strobe indices.
package pport_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_INTR = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int CB_IBF = 7;
    localparam int CB_OBF = 6;
    localparam int CB_OVF = 5;
    localparam int CB_EN  = 4;
    localparam int CB_DIRW = 3;

    localparam int IB_FLAG = 0;
    localparam int IB_ENA  = 1;

    localparam int PIN_CS    = 0;
    localparam int PIN_RD    = 1;
    localparam int PIN_WR    = 2;
    localparam int PIN_COUNT = 3;
endpackage

// File: rtl/pport_sync.sv
// Multi-flop synchronizer for a group of asynchronous active-low pins,
// plus one extra register that detects rising edges of the synchronized
// level. Assumes STAGES >= 2 and that each pin stays stable for several
// clock cycles between changes.
module pport_sync #(
    parameter int W = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] stg;
    logic [W-1:0]             prev;

    // Shift the raw pins through the synchronizer chain; reset to idle (high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg  <= '1;
            prev <= '1;
        end else begin
            stg[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            prev <= stg[STAGES-1];
        end
    end

    // Expose the synchronized level and its rising edge.
    always_comb begin
        level = stg[STAGES-1];
        rise  = stg[STAGES-1] & ~prev;
    end
endmodule

// File: rtl/pport_flags.sv
// Inbound latch and the full/overflow flags. Assumes the event inputs
// are single-cycle pulses in the clk domain. An external write beats a
// same-cycle CPU read; a CPU write beats a same-cycle external read.
module pport_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_evt,
    input  logic          rd_evt,
    input  logic          cpu_rd_data,
    input  logic          cpu_wr_data,
    input  logic          ovf_clr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] in_latch,
    output logic          ibf,
    output logic          obf,
    output logic          ovf
);
    logic wr_take;
    logic wr_lost;

    // Decide whether an external write is accepted or overflows.
    always_comb begin
        wr_take = en && wr_evt && (!ibf || cpu_rd_data);
        wr_lost = en && wr_evt && ibf && !cpu_rd_data;
    end

    // Capture the inbound byte and update the three flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_latch <= '0;
            ibf      <= 1'b0;
            obf      <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            if (wr_take) in_latch <= din;

            if (!en)              ibf <= 1'b0;
            else if (wr_evt)      ibf <= 1'b1;
            else if (cpu_rd_data) ibf <= 1'b0;

            if (!en)              obf <= 1'b0;
            else if (cpu_wr_data) obf <= 1'b1;
            else if (rd_evt)      obf <= 1'b0;

            if (wr_lost)          ovf <= 1'b1;
            else if (ovf_clr)     ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/pport_irq.sv
// Latched access interrupt flag with its enable. Assumes acc_evt is a
// single-cycle pulse. A hardware set beats a same-cycle software clear.
module pport_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic acc_evt,
    input  logic wr_reg,
    input  logic wd_flag,
    input  logic wd_ena,
    output logic flag,
    output logic ena,
    output logic irq
);
    // Hold the access flag and the software enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            ena  <= 1'b0;
        end else begin
            if (en && acc_evt)         flag <= 1'b1;
            else if (wr_reg && !wd_flag) flag <= 1'b0;
            if (wr_reg) ena <= wd_ena;
        end
    end

    // Request only while both flag and enable are set.
    assign irq = flag && ena;
endmodule

// File: rtl/pport_slave.sv
// Parallel slave port top level. External strobes are active low and
// asynchronous. The CPU interface is synchronous to clk. Assumes DW >= 8,
// because the control register occupies the low eight bits of cpu_rdata.
module pport_slave
    import pport_pkg::*;
#(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          ext_cs_n,
    input  logic          ext_rd_n,
    input  logic          ext_wr_n,
    input  logic [DW-1:0] ext_din,
    output logic [DW-1:0] ext_dout,
    output logic          ext_doe,
    output logic          irq
);
    reg_sel_e                 sel;
    logic [PIN_COUNT-1:0]     pins, pin_lvl, pin_rise;
    logic                     wr_evt, rd_evt;
    logic                     cpu_rd_data, cpu_wr_data, cpu_wr_ctrl, cpu_wr_intr;
    logic                     mode_en;
    logic [CB_DIRW-1:0]       dir_bits;
    logic [DW-1:0]            out_latch, in_latch;
    logic                     ibf, obf, ovf;
    logic                     irq_flag, irq_ena;
    logic [7:0]               ctrl_view;

    // Decode the CPU access into per-register strobes.
    always_comb begin
        sel         = reg_sel_e'(cpu_addr);
        cpu_rd_data = cpu_rd && (sel == REG_DATA);
        cpu_wr_data = cpu_wr && (sel == REG_DATA);
        cpu_wr_ctrl = cpu_wr && (sel == REG_CTRL);
        cpu_wr_intr = cpu_wr && (sel == REG_INTR);
    end

    // Gather the strobe pins into one vector for the synchronizer.
    always_comb begin
        pins         = '1;
        pins[PIN_CS] = ext_cs_n;
        pins[PIN_RD] = ext_rd_n;
        pins[PIN_WR] = ext_wr_n;
    end

    pport_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .level    (pin_lvl),
        .rise     (pin_rise)
    );

    // A strobe release counts as an access only while chip select is low.
    always_comb begin
        wr_evt = pin_rise[PIN_WR] && !pin_lvl[PIN_CS];
        rd_evt = pin_rise[PIN_RD] && !pin_lvl[PIN_CS];
    end

    // Control bits and the outbound latch, both written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en   <= 1'b0;
            dir_bits  <= '1;
            out_latch <= '0;
        end else begin
            if (cpu_wr_ctrl) begin
                mode_en  <= cpu_wdata[CB_EN];
                dir_bits <= cpu_wdata[CB_DIRW-1:0];
            end
            if (cpu_wr_data) out_latch <= cpu_wdata;
        end
    end

    pport_flags #(.DW(DW)) i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (mode_en),
        .wr_evt      (wr_evt),
        .rd_evt      (rd_evt),
        .cpu_rd_data (cpu_rd_data),
        .cpu_wr_data (cpu_wr_data),
        .ovf_clr     (cpu_wr_ctrl && !cpu_wdata[CB_OVF]),
        .din         (ext_din),
        .in_latch    (in_latch),
        .ibf         (ibf),
        .obf         (obf),
        .ovf         (ovf)
    );

    pport_irq i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode_en),
        .acc_evt (wr_evt || rd_evt),
        .wr_reg  (cpu_wr_intr),
        .wd_flag (cpu_wdata[IB_FLAG]),
        .wd_ena  (cpu_wdata[IB_ENA]),
        .flag    (irq_flag),
        .ena     (irq_ena),
        .irq     (irq)
    );

    // Assemble the control/status view.
    always_comb begin
        ctrl_view                 = '0;
        ctrl_view[CB_IBF]         = ibf;
        ctrl_view[CB_OBF]         = obf;
        ctrl_view[CB_OVF]         = ovf;
        ctrl_view[CB_EN]          = mode_en;
        ctrl_view[CB_DIRW-1:0]    = dir_bits;
    end

    // CPU read mux; reading has no side effect here.
    always_comb begin
        cpu_rdata = '0;
        case (sel)
            REG_DATA: cpu_rdata = in_latch;
            REG_CTRL: cpu_rdata[7:0] = ctrl_view;
            REG_INTR: begin
                cpu_rdata[IB_FLAG] = irq_flag;
                cpu_rdata[IB_ENA]  = irq_ena;
            end
            default:  cpu_rdata = '0;
        endcase
    end

    // Drive the external bus straight from the pins while a read is active.
    always_comb begin
        ext_dout = out_latch;
        ext_doe  = mode_en && !ext_cs_n && !ext_rd_n;
    end
endmodule

// File: rtl/pport_slave_chk.sv
// Property checker for pport_slave, attached by bind. Observes the
// decoded events, the CPU strobes and the flag state.
module pport_slave_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en,
    input logic          wr_evt,
    input logic          rd_evt,
    input logic          cpu_rd_data,
    input logic          cpu_wr_data,
    input logic [DW-1:0] in_latch,
    input logic          ibf,
    input logic          obf,
    input logic          ovf,
    input logic          irq_flag
);
    // R2: external read clears outbound full unless a CPU write collides.
    p_obf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && rd_evt && !cpu_wr_data) |=> !obf);

    // R3: an accepted external write leaves inbound full set.
    p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && wr_evt) |=> ibf);

    // R4: a write onto a full latch flags overflow and keeps the old byte.
    p_keep_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && wr_evt && ibf && !cpu_rd_data) |=> (ovf && $stable(in_latch)));

    // R5: with mode off, both full flags are clear one cycle later.
    p_flags_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (!ibf && !obf));

    // R7: each completed access in mode sets the access flag.
    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && (wr_evt || rd_evt)) |=> irq_flag);

    // R7: the access flag only rises after an access in mode.
    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(mode_en && (wr_evt || rd_evt)));

    // R9: a write colliding with a CPU data read never flags overflow.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && wr_evt && cpu_rd_data) |=> (ibf && (ovf == $past(ovf))));
endmodule

bind pport_slave pport_slave_chk #(.DW(DW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_en     (mode_en),
    .wr_evt      (wr_evt),
    .rd_evt      (rd_evt),
    .cpu_rd_data (cpu_rd_data),
    .cpu_wr_data (cpu_wr_data),
    .in_latch    (in_latch),
    .ibf         (ibf),
    .obf         (obf),
    .ovf         (ovf),
    .irq_flag    (irq_flag)
);

// File: tb/test_pport_slave.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module test_pport_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] ext_din = 8'h00;
    logic [7:0] ext_dout;
    logic       ext_doe, irq;
    int         n_tot = 0, n_bad = 0;

    always #10 clk = ~clk;

    pport_slave i_pport_slave (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_din(ext_din), .ext_dout(ext_dout), .ext_doe(ext_doe), .irq(irq)
    );

    // op[26:24] arg[23:16] exp_ctl[15:8] exp_dat[7:0]
    // op: 0 cpu data write, 1 ext write, 2 ext read, 3 cpu data read, 4 cpu ctrl write
    localparam logic [26:0] VEC [12] = '{
        {3'd4, 8'h37, 8'h17, 8'h00},
        {3'd0, 8'hA5, 8'h57, 8'h00},
        {3'd2, 8'h00, 8'h17, 8'hA5},
        {3'd1, 8'h3C, 8'h97, 8'h00},
        {3'd3, 8'h00, 8'h17, 8'h3C},
        {3'd1, 8'h11, 8'h97, 8'h00},
        {3'd1, 8'h22, 8'hB7, 8'h00},
        {3'd3, 8'h00, 8'h37, 8'h11},
        {3'd4, 8'hD7, 8'h17, 8'h00},
        {3'd0, 8'h5A, 8'h57, 8'h00},
        {3'd0, 8'h66, 8'h57, 8'h00},
        {3'd2, 8'h00, 8'h17, 8'h66}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tot++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic cpu_read(output logic [7:0] d);
        @(negedge clk);
        cpu_addr = 2'd0; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic ext_write(input logic [7:0] d, input logic sel);
        @(negedge clk);
        ext_cs_n = !sel; ext_wr_n = 1'b0; ext_din = d;
        repeat (3) @(negedge clk);
        ext_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic ext_read(output logic [7:0] d, output logic oe);
        @(negedge clk);
        ext_cs_n = 1'b0; ext_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 d = ext_dout; oe = ext_doe;
        @(negedge clk);
        ext_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL all actual=hung expected=finished (watchdog)");
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, dd;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(2'd1, v); chk("R1 ctrl", v, 8'h07);
        peek(2'd2, v); chk("R1 intr", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 doe", {7'd0, ext_doe}, 8'h00);
        chk("R1 dout", ext_dout, 8'h00);

        // Table walk: R2, R3, R4, R6
        for (int i = 0; i < 12; i++) begin
            logic [2:0] op;
            logic [7:0] arg, ectl, edat;
            {op, arg, ectl, edat} = VEC[i];
            case (op)
                3'd0: cpu_write(2'd0, arg);
                3'd1: ext_write(arg, 1'b1);
                3'd2: begin
                    ext_read(dd, oe);
                    chk("R2 ext read data", dd, edat);
                    chk("R10 doe in read", {7'd0, oe}, 8'h01);
                end
                3'd3: begin
                    cpu_read(dd);
                    chk("R3/R4 cpu read data", dd, edat);
                end
                default: cpu_write(2'd1, arg);
            endcase
            peek(2'd1, v);
            chk("R2/R3/R4/R6 table ctrl", v, ectl);
        end

        // R7: interrupt flag and enable
        peek(2'd2, v); chk("R7 flag latched", v, 8'h01);
        chk("R7 irq gated", {7'd0, irq}, 8'h00);
        cpu_write(2'd2, 8'h02);
        peek(2'd2, v); chk("R7 clear+enable", v, 8'h02);
        ext_write(8'h44, 1'b1);
        peek(2'd2, v); chk("R7 set by write", v, 8'h03);
        chk("R7 irq high", {7'd0, irq}, 8'h01);
        cpu_write(2'd2, 8'h03);
        peek(2'd2, v); chk("R7 one no clear", v, 8'h03);
        cpu_write(2'd2, 8'h02);
        peek(2'd2, v); chk("R7 cleared", v, 8'h02);
        chk("R7 irq low", {7'd0, irq}, 8'h00);
        cpu_read(dd); chk("R3 read", dd, 8'h44);

        // R8: chip select high ignored; exact latency
        ext_write(8'hEE, 1'b0);
        peek(2'd1, v); chk("R8 cs high ctrl", v, 8'h17);
        peek(2'd2, v); chk("R8 cs high intr", v, 8'h02);
        @(negedge clk);
        ext_cs_n = 1'b0; ext_wr_n = 1'b0; ext_din = 8'h5E;
        repeat (3) @(negedge clk);
        ext_wr_n = 1'b1; cpu_addr = 2'd1;
        repeat (2) @(negedge clk);
        #1 chk("R8 not yet", cpu_rdata, 8'h17);
        @(negedge clk);
        #1 chk("R8 third cycle", cpu_rdata, 8'h97);
        repeat (2) @(negedge clk);
        ext_cs_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: external write collides with CPU data read
        ext_cs_n = 1'b0; ext_wr_n = 1'b0; ext_din = 8'h6F;
        repeat (3) @(negedge clk);
        ext_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cpu_addr = 2'd0; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        repeat (2) @(negedge clk);
        ext_cs_n = 1'b1;
        peek(2'd1, v); chk("R9 write wins ctrl", v, 8'h97);
        cpu_read(dd); chk("R9 new byte", dd, 8'h6F);
        peek(2'd1, v); chk("R9 after read", v, 8'h17);

        // R6: overflow survives mode off, cleared by bit5 = 0
        ext_write(8'h01, 1'b1);
        ext_write(8'h02, 1'b1);
        peek(2'd1, v); chk("R4 overflow", v, 8'hB7);
        cpu_write(2'd1, 8'h27);
        peek(2'd1, v); chk("R6 ovf kept off", v, 8'h27);
        cpu_write(2'd1, 8'h37);
        peek(2'd1, v); chk("R6 ovf kept on", v, 8'h37);
        cpu_read(dd); chk("R4 first kept", dd, 8'h01);
        cpu_write(2'd1, 8'h17);
        peek(2'd1, v); chk("R6 ovf cleared", v, 8'h17);

        // R5 / R10: mode off ignores strobes
        cpu_write(2'd2, 8'h02);
        cpu_write(2'd1, 8'h07);
        peek(2'd1, v); chk("R5 mode off", v, 8'h07);
        ext_write(8'h99, 1'b1);
        peek(2'd1, v); chk("R5 write ignored ctrl", v, 8'h07);
        peek(2'd2, v); chk("R5 no irq flag", v, 8'h02);
        peek(2'd0, v); chk("R5 latch unchanged", v, 8'h01);
        ext_read(dd, oe);
        chk("R10 doe off", {7'd0, oe}, 8'h00);
        cpu_write(2'd0, 8'h77);
        peek(2'd1, v); chk("R5 no obf off", v, 8'h07);
        cpu_write(2'd1, 8'h17);
        peek(2'd1, v); chk("R5 obf after on", v, 8'h17);
        ext_read(dd, oe);
        chk("R10 doe on", {7'd0, oe}, 8'h01);
        chk("R2 dout", dd, 8'h77);
        peek(2'd2, v); chk("R7 read sets flag", v, 8'h03);

        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule